// File: doc/BRIEF.md
# Differential Quadrature Encoder Counter

This block decodes one incremental motor encoder whose two quadrature channels each arrive as a balanced pair of lines. Each line pair is first passed through a two-flop synchroniser. After that the block rebuilds the A and B channels from the positive lines and counts every legal Gray-code step of (A, B) into a 16-bit up/down position counter.

The block also watches the line pairs. If a pair stops being complementary for two samples in a row, a sticky line-fault flag is raised. A step in which both channels change at once is an illegal jump: it is flagged and not counted. Both flags stay set until a clear pulse arrives. A single writable enable bit freezes the counter and suppresses fault detection, so software can park an unused or faulty encoder.

The position is read over a byte-wide serial path, low byte first. The low byte is always live. A read strobe on the low byte captures the matching high byte, so the two halves always belong to the same count.

Top module: `quad_diff_counter`

## Requirements
- R1: After reset the count is 0, both fault flags are 0, and the enable bit is 1.
- R2: With the encoder enabled, each forward step of (A,B) adds one to the count. The forward sequence is 00→01→11→10→00, with A as the upper bit, A taken from the positive line of pair A and B from the positive line of pair B.
- R3: Each step in the reverse direction of that sequence subtracts one from the count.
- R4: The count wraps modulo 65536 in both directions.
- R5: A change of both A and B between two samples sets `jump_err` and leaves the count unchanged.
- R6: A pair whose two lines are equal for two or more consecutive synchronised samples sets `line_err`. A single bad sample does not set it. Steps are not counted while a pair is bad.
- R7: A one-cycle `err_clr` pulse clears both fault flags. Without a clear, a flag holds its value. If a new fault and a clear arrive in the same cycle, the fault wins.
- R8: While the enable bit is 0 (written via `en_wr`/`en_wdata`), the count holds and neither flag can be set. When counting is re-enabled, channel moves made while disabled cause no count.
- R9: A `rd_lo` pulse captures bits 15..8 of the count into `cnt_hi` one cycle later. `cnt_lo` always shows bits 7..0.
- R10: A step on the input pins reaches the count on the third rising clock edge after the pins change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_pos_i | input | 1 | Channel A, positive line |
| a_neg_i | input | 1 | Channel A, negative line |
| b_pos_i | input | 1 | Channel B, positive line |
| b_neg_i | input | 1 | Channel B, negative line |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_wdata | input | 1 | Value written to the enable bit |
| err_clr | input | 1 | Clears both fault flags |
| rd_lo | input | 1 | Low-byte read strobe; captures the high byte |
| enabled | output | 1 | Current enable bit |
| cnt_lo | output | 8 | Live count bits 7..0 |
| cnt_hi | output | 8 | Count bits 15..8 captured at the last `rd_lo` |
| line_err | output | 1 | Sticky line-pair fault flag |
| jump_err | output | 1 | Sticky illegal-jump flag |

## Verification
A pin step shows on `cnt_lo` at the third rising edge after the pins change. The bench drives the pins on a falling edge and samples two falling edges later, where it expects the old value, then three falling edges later, where it expects the new one. A line fault needs one more edge to be confirmed, so its flag is sampled four or more edges after the fault starts. The glitch case is sampled at the same distance to show that the flag stays clear. `jump_err` rises on the same edge at which a count would have changed. `cnt_hi` is checked at the falling edge that follows the capture edge of the `rd_lo` strobe.

// File: rtl/quad_diff_counter.sv
module quad_diff_counter #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_pos_i,
  input  logic              a_neg_i,
  input  logic              b_pos_i,
  input  logic              b_neg_i,
  input  logic              en_wr,
  input  logic              en_wdata,
  input  logic              err_clr,
  input  logic              rd_lo,
  output logic              enabled,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic              line_err,
  output logic              jump_err
);
  localparam int CNT_W = 2 * BYTE_W;
  localparam logic [3:0] IDLE_LINES = 4'b0101;

  logic [3:0]       sync_q [SYNC_STAGES];
  logic [3:0]       lines;
  logic             pair_ok, ch_a, ch_b;
  logic [1:0]       prev_q;
  logic [3:0]       trans;
  logic             step_up, step_dn, jump;
  logic             en_q, bad_q;
  logic [CNT_W-1:0] count_q;
  logic [BYTE_W-1:0] hi_hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= IDLE_LINES;
    end else begin
      sync_q[0] <= {a_pos_i, a_neg_i, b_pos_i, b_neg_i};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign lines   = sync_q[SYNC_STAGES-1];
  assign pair_ok = (lines[3] ^ lines[2]) & (lines[1] ^ lines[0]);
  assign ch_a    = lines[3];
  assign ch_b    = lines[1];
  assign trans   = {prev_q, ch_a, ch_b};

  always_comb begin
    step_up = 1'b0;
    step_dn = 1'b0;
    unique case (trans)
      4'b0001, 4'b0111, 4'b1110, 4'b1000: step_up = 1'b1;
      4'b0010, 4'b1011, 4'b1101, 4'b0100: step_dn = 1'b1;
      default: ;
    endcase
  end

  assign jump = (prev_q[1] != ch_a) && (prev_q[0] != ch_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= 2'b00;
      count_q   <= '0;
      en_q      <= 1'b1;
      bad_q     <= 1'b0;
      line_err  <= 1'b0;
      jump_err  <= 1'b0;
      hi_hold_q <= '0;
    end else begin
      if (pair_ok) prev_q <= {ch_a, ch_b};
      if (en_q && pair_ok) begin
        if (step_up)      count_q <= count_q + 1'b1;
        else if (step_dn) count_q <= count_q - 1'b1;
      end
      if (en_wr) en_q <= en_wdata;
      bad_q <= en_q & ~pair_ok;
      if (en_q && !pair_ok && bad_q) line_err <= 1'b1;
      else if (err_clr)              line_err <= 1'b0;
      if (en_q && pair_ok && jump)   jump_err <= 1'b1;
      else if (err_clr)              jump_err <= 1'b0;
      if (rd_lo) hi_hold_q <= count_q[CNT_W-1:BYTE_W];
    end
  end

  assign enabled = en_q;
  assign cnt_lo  = count_q[BYTE_W-1:0];
  assign cnt_hi  = hi_hold_q;
endmodule

module quad_diff_counter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enabled,
  input logic             err_clr,
  input logic             rd_lo,
  input logic             line_err,
  input logic             jump_err,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W/2-1:0] cnt_hi
);
  // R2 R3 R4
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (CNT_W'(count - $past(count)) == CNT_W'(0)) ||
             (CNT_W'(count - $past(count)) == CNT_W'(1)) ||
             (CNT_W'(count - $past(count)) == {CNT_W{1'b1}}));
  // R5
  jump_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jump_err) |-> $stable(count));
  // R7
  line_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_err && !err_clr |=> line_err);
  // R7
  jump_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jump_err && !err_clr |=> jump_err);
  // R8
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |=> $stable(count));
  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |=> !$rose(line_err) && !$rose(jump_err));
  // R9
  hi_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> cnt_hi == $past(count[CNT_W-1:CNT_W/2]));
endmodule

bind quad_diff_counter quad_diff_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enabled(enabled), .err_clr(err_clr),
  .rd_lo(rd_lo), .line_err(line_err), .jump_err(jump_err),
  .count(count_q), .cnt_hi(cnt_hi)
);

// File: tb/quad_diff_counter_tb.sv
module quad_diff_counter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_pos_i = 1'b0, a_neg_i = 1'b1, b_pos_i = 1'b0, b_neg_i = 1'b1;
  logic en_wr = 1'b0, en_wdata = 1'b0, err_clr = 1'b0, rd_lo = 1'b0;
  logic enabled, line_err, jump_err;
  logic [7:0] cnt_lo, cnt_hi;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  quad_diff_counter u_dut (
    .clk(clk), .rst_n(rst_n), .a_pos_i(a_pos_i), .a_neg_i(a_neg_i),
    .b_pos_i(b_pos_i), .b_neg_i(b_neg_i), .en_wr(en_wr), .en_wdata(en_wdata),
    .err_clr(err_clr), .rd_lo(rd_lo), .enabled(enabled), .cnt_lo(cnt_lo),
    .cnt_hi(cnt_hi), .line_err(line_err), .jump_err(jump_err)
  );

  // {A, B, expected count}
  localparam int NVEC = 11;
  localparam logic [17:0] VEC [NVEC] = '{
    {2'b01, 16'd1},     {2'b11, 16'd2},     {2'b10, 16'd3},
    {2'b00, 16'd4},     {2'b10, 16'd3},     {2'b11, 16'd2},
    {2'b01, 16'd1},     {2'b00, 16'd0},     {2'b10, 16'hFFFF},
    {2'b00, 16'd0},     {2'b01, 16'd1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_ab(input logic a, input logic b);
    a_pos_i = a; a_neg_i = ~a; b_pos_i = b; b_neg_i = ~b;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_count(output logic [15:0] v);
    rd_lo = 1'b1; cyc(1); rd_lo = 1'b0;
    v = {cnt_hi, cnt_lo};
  endtask

  task automatic pulse_clr();
    err_clr = 1'b1; cyc(1); err_clr = 1'b0;
  endtask

  initial begin
    logic [15:0] v;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
    read_count(v);
    check("R1 count", v, 16'd0);
    check("R1 flags", {line_err, jump_err}, 2'b00);
    check("R1 enable", enabled, 1'b1);

    for (int i = 0; i < NVEC; i++) begin
      set_ab(VEC[i][17], VEC[i][16]);
      cyc(4);
      read_count(v);
      check(i == 8 || i == 9 ? "R4 wrap" : (i >= 4 && i <= 8 ? "R3 reverse" : "R2 forward"),
            v, VEC[i][15:0]);
    end

    // R10 latency: state 01 -> 11 counts up on third edge
    set_ab(1'b1, 1'b1);
    cyc(2);
    check("R10 before third edge", cnt_lo, 8'd1);
    cyc(1);
    check("R10 at third edge", cnt_lo, 8'd2);
    set_ab(1'b0, 1'b1);
    cyc(4);
    check("R3 back to 1", cnt_lo, 8'd1);

    // R6 single bad sample ignored
    a_neg_i = 1'b0; cyc(1); a_neg_i = 1'b1;
    cyc(5);
    check("R6 glitch ignored", line_err, 1'b0);
    // R6 persistent fault
    a_pos_i = 1'b1; a_neg_i = 1'b1;
    cyc(4);
    check("R6 fault flagged", line_err, 1'b1);
    set_ab(1'b0, 1'b1);
    cyc(4);
    check("R6 no count during fault", cnt_lo, 8'd1);
    pulse_clr();
    cyc(1);
    check("R7 line clear", line_err, 1'b0);

    // R5 jump 01 -> 10
    set_ab(1'b1, 1'b0);
    cyc(4);
    check("R5 jump flagged", jump_err, 1'b1);
    check("R5 jump not counted", cnt_lo, 8'd1);
    cyc(2);
    check("R7 jump holds", jump_err, 1'b1);
    pulse_clr();
    cyc(1);
    check("R7 jump clear", jump_err, 1'b0);

    // R8 disable
    en_wdata = 1'b0; en_wr = 1'b1; cyc(1); en_wr = 1'b0;
    check("R8 enable bit", enabled, 1'b0);
    set_ab(1'b1, 1'b1);
    cyc(4);
    check("R8 hold", cnt_lo, 8'd1);
    b_pos_i = 1'b0;
    cyc(4);
    check("R8 no line fault", line_err, 1'b0);
    set_ab(1'b0, 1'b0);
    cyc(4);
    check("R8 no jump fault", jump_err, 1'b0);
    set_ab(1'b1, 1'b1);
    cyc(4);
    en_wdata = 1'b1; en_wr = 1'b1; cyc(1); en_wr = 1'b0;
    cyc(3);
    check("R8 re-enable no count", cnt_lo, 8'd1);
    set_ab(1'b0, 1'b1);
    cyc(4);
    read_count(v);
    check("R8 counts after re-enable", v, 16'd0);

    // R9 high byte captured at strobe
    set_ab(1'b0, 1'b0);
    cyc(4);
    read_count(v);
    check("R9 high byte after wrap", v, 16'hFFFF);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule